// File: doc/BRIEF.md
# Sleep-Time Interrupt Recorder and Replayer

This block sits between a bank of external interrupt lines and a parent interrupt controller that may be powered down. Each line is watched for a configured event (rising edge, falling edge, high level or low level). When the event is seen, a per-line status bit is set. Recording runs whether or not the block is enabled, so no event is lost while the parent controller sleeps.

Software sets up the lines through a word-addressed register bus with one bit per line. Mask, sense and polarity each have a write-one-to-set offset and a write-one-to-clear offset, and status bits are cleared through an acknowledge group. When the parent wakes, software writes a flush command. The block then walks the lines in ascending order, one line per clock. For each recorded and unmasked line it raises that line's output for one cycle and clears its status. The flush bit drops by itself when the walk ends.

Top module: `wake_irq_recorder`

## Requirements
- R1: Line n maps to bit (n mod 32) of the word at byte offset group_base + 4*(n div 32). The group bases are: acknowledge 0x40, mask-set 0xC0, mask-clear 0x100, sense-set 0x180, sense-clear 0x1C0, polarity-set 0x240, polarity-clear 0x280. Control sits at 0x300. Bits with no line behind them read 0.
- R2: Mask, sense and polarity bits are set by writing 1 to the set offset and cleared by writing 1 to the clear offset. Zero bits leave state unchanged. Reading either offset of a pair returns the current state of that group.
- R3: Each input passes through two synchronizing flops, and an edge is found by comparing two successive synchronized samples. Sense 1 selects level and 0 selects edge. Polarity 1 selects high or rising and 0 selects low or falling.
- R4: A line's status is set whenever its configured event occurs, even with the enable bit (control bit 0) clear.
- R5: Writing 1 to a line's bit in the acknowledge group clears its status. Reading the acknowledge group returns the status. An event in the same cycle as the acknowledge leaves the status set.
- R6: While control bit 1 (edge-only) is set, lines in level mode record nothing. Edge-mode lines still record.
- R7: A write to control with bit 2 (flush) and bit 0 both 1 starts a replay. The replay visits lines 0 to N-1, one per cycle. A recorded, unmasked line gets a one-cycle output pulse and its status is cleared. A recorded but masked line gets no pulse and stays recorded.
- R8: Control reads back {flush, edge-only, enable} in bits 2..0. The flush bit reads 1 from the starting write until the N-cycle replay ends. A flush write while a replay runs, or with bit 0 clear, starts nothing.
- R9: After reset every register is zero and all outputs are low.
- R10: Outputs are low except for replay pulses, and at most one output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W | Byte address of the register word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqIn | input | NUM_LINES | External interrupt lines (asynchronous) |
| irqOut | output | NUM_LINES | Replay pulses to the parent controller |

## Verification
The hardest case to reach is an acknowledge that lands in the same clock as a fresh edge on the same line. The edge has to get through the synchronizer and the previous-sample compare before the acknowledge write is sampled. The bench raises the input, waits exactly two falling clock edges, and then issues the acknowledge, so the write and the detected edge meet at one rising edge. A behavioural model, compared every cycle, then confirms that the status stays set and that the later replay pulses it.

// File: rtl/wir_pkg.sv
`timescale 1ns/1ps
package wir_pkg;
  localparam int WORD_SEL_W = 4;
  localparam int LINE_SEL_W = 9;
  localparam int NUM_ARRAY_GRPS = 7;
  localparam int CTRL_OFS = 'h300;

  typedef enum logic [3:0] {
    GRP_NONE, GRP_ACK, GRP_MSET, GRP_MCLR, GRP_SSET, GRP_SCLR, GRP_PSET, GRP_PCLR, GRP_CTRL
  } grp_e;

  // byte bases, in the order of grp_e starting at GRP_ACK
  localparam int GRP_BASE [NUM_ARRAY_GRPS] = '{'h40, 'hC0, 'h100, 'h180, 'h1C0, 'h240, 'h280};

  typedef struct packed {
    logic                  wr;
    grp_e                  grp;
    logic [WORD_SEL_W-1:0] word;
    logic                  replayStep;
    logic [LINE_SEL_W-1:0] replayIdx;
    logic                  edgeOnly;
  } strobe_t;
endpackage

// File: rtl/wir_sync.sv
`timescale 1ns/1ps
module wir_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/wir_ctrl.sv
`timescale 1ns/1ps
module wir_ctrl
  import wir_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        ctrlWdata,
  input  logic [31:0]       arrayRdata,
  output logic [31:0]       busRdata,
  output strobe_t           strb
);
  localparam int WORDS = (NUM_LINES + 31) / 32;

  grp_e                  grp;
  logic [WORD_SEL_W-1:0] word;
  int                    addrI;
  logic                  enQ, edgeOnlyQ, busyQ;
  logic [LINE_SEL_W-1:0] idxQ;

  always_comb begin
    grp   = GRP_NONE;
    word  = '0;
    addrI = int'(busAddr);
    if (busAddr[1:0] == 2'b00) begin
      if (addrI == CTRL_OFS) grp = GRP_CTRL;
      for (int g = 0; g < NUM_ARRAY_GRPS; g++) begin
        if (addrI >= GRP_BASE[g] && addrI < GRP_BASE[g] + 4 * WORDS) begin
          grp  = grp_e'(4'(g + 1));
          word = WORD_SEL_W'((addrI - GRP_BASE[g]) / 4);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      edgeOnlyQ <= 1'b0;
      busyQ     <= 1'b0;
      idxQ      <= '0;
    end else begin
      if (busyQ) begin
        if (idxQ == LINE_SEL_W'(NUM_LINES - 1)) busyQ <= 1'b0;
        else idxQ <= idxQ + 1'b1;
      end
      if (busWrEn && grp == GRP_CTRL) begin
        enQ       <= ctrlWdata[0];
        edgeOnlyQ <= ctrlWdata[1];
        if (ctrlWdata[2] && ctrlWdata[0] && !busyQ) begin
          busyQ <= 1'b1;
          idxQ  <= '0;
        end
      end
    end
  end

  always_comb begin
    strb.wr         = busWrEn;
    strb.grp        = grp;
    strb.word       = word;
    strb.replayStep = busyQ;
    strb.replayIdx  = idxQ;
    strb.edgeOnly   = edgeOnlyQ;
    busRdata = (grp == GRP_CTRL) ? {29'b0, busyQ, edgeOnlyQ, enQ} : arrayRdata;
  end

  // R8: the walk index stays inside the line range while replaying
  a_r8_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (idxQ < LINE_SEL_W'(NUM_LINES)));
  // R8: a replay only ends after visiting the last line
  a_r8_ends_at_last: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> ($past(idxQ) == LINE_SEL_W'(NUM_LINES - 1)));
endmodule

// File: rtl/wir_datapath.sv
`timescale 1ns/1ps
module wir_datapath
  import wir_pkg::*;
#(
  parameter int NUM_LINES = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [31:0]          busWdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [31:0]          arrayRdata,
  output logic [NUM_LINES-1:0] irqOut
);
  logic [NUM_LINES-1:0] syncS, prevQ;
  logic [NUM_LINES-1:0] maskQ, senseQ, polQ, statusQ, outQ;
  logic [NUM_LINES-1:0] wrBits, stepVec, fire;
  logic [NUM_LINES-1:0] riseV, fallV, edgeEv, lvlEv, evVec;

  wir_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .rstN(rstN), .din(irqIn), .dout(syncS)
  );

  function automatic logic hit(input strobe_t s, input grp_e g);
    return s.wr && (s.grp == g);
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      wrBits[i]  = (strb.word == WORD_SEL_W'(i / 32)) && busWdata[i % 32];
      stepVec[i] = strb.replayStep && (strb.replayIdx == LINE_SEL_W'(i));
    end
    riseV  = syncS & ~prevQ;
    fallV  = ~syncS & prevQ;
    edgeEv = (polQ & riseV) | (~polQ & fallV);
    lvlEv  = (polQ & syncS) | (~polQ & ~syncS);
    evVec  = (senseQ & lvlEv & {NUM_LINES{~strb.edgeOnly}}) | (~senseQ & edgeEv);
    fire   = stepVec & statusQ & ~maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ   <= '0;
      maskQ   <= '0;
      senseQ  <= '0;
      polQ    <= '0;
      statusQ <= '0;
      outQ    <= '0;
    end else begin
      prevQ <= syncS;
      outQ  <= fire;
      statusQ <= (statusQ & ~(hit(strb, GRP_ACK) ? wrBits : '0) & ~fire) | evVec;
      if (hit(strb, GRP_MSET)) maskQ <= maskQ | wrBits;
      else if (hit(strb, GRP_MCLR)) maskQ <= maskQ & ~wrBits;
      if (hit(strb, GRP_SSET)) senseQ <= senseQ | wrBits;
      else if (hit(strb, GRP_SCLR)) senseQ <= senseQ & ~wrBits;
      if (hit(strb, GRP_PSET)) polQ <= polQ | wrBits;
      else if (hit(strb, GRP_PCLR)) polQ <= polQ & ~wrBits;
    end
  end

  logic [NUM_LINES-1:0] rdVec;
  always_comb begin
    case (strb.grp)
      GRP_ACK:            rdVec = statusQ;
      GRP_MSET, GRP_MCLR: rdVec = maskQ;
      GRP_SSET, GRP_SCLR: rdVec = senseQ;
      GRP_PSET, GRP_PCLR: rdVec = polQ;
      default:            rdVec = '0;
    endcase
    arrayRdata = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (strb.word == WORD_SEL_W'(i / 32)) arrayRdata[i % 32] = rdVec[i];
  end

  assign irqOut = outQ;

  // R10: at most one replay pulse at a time
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outQ));
  // R10: a pulse only follows a replay step from the control side
  a_r10_pulse_from_replay: assert property (@(posedge clk) disable iff (!rstN)
    (|outQ) |-> $past(strb.replayStep));
  // R7: a pulsed line had been recorded
  a_r7_pulse_was_recorded: assert property (@(posedge clk) disable iff (!rstN)
    (outQ & ~$past(statusQ)) == '0);
  // R4: status only rises after a detected event
  a_r4_status_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~$past(statusQ) & ~$past(evVec)) == '0);
endmodule

// File: rtl/wake_irq_recorder.sv
`timescale 1ns/1ps
module wake_irq_recorder
  import wir_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] irqOut
);
  strobe_t     strb;
  logic [31:0] arrayRdata;

  wir_ctrl #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .ctrlWdata(busWdata[2:0]), .arrayRdata(arrayRdata),
    .busRdata(busRdata), .strb(strb)
  );

  wir_datapath #(.NUM_LINES(NUM_LINES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .irqIn(irqIn), .arrayRdata(arrayRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/test_wake_irq_recorder.sv
`timescale 1ns/1ps
module test_wake_irq_recorder;
  localparam int N = 40;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] irqIn = '0;
  logic [N-1:0] irqOut;

  always #2.5 clk = ~clk;

  wake_irq_recorder #(.NUM_LINES(N), .ADDR_W(ADDR_W)) i_wake_irq_recorder (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------- behavioural reference model ----------
  logic [N-1:0] mS1, mS2, mPrev, mMask, mSense, mPol, mStatus, mOut;
  logic mEn, mEdge, mBusy;
  int mIdx;

  function automatic bit wHit(input int base, input int i);
    return busWrEn && (int'(busAddr) == base + 4 * (i / 32)) && busWdata[i % 32];
  endfunction

  function automatic logic [31:0] mRead(input int a);
    int bases[7] = '{'h40, 'hC0, 'h100, 'h180, 'h1C0, 'h240, 'h280};
    logic [N-1:0] v;
    logic [31:0] r = '0;
    if (a == 'h300) return {29'b0, mBusy, mEdge, mEn};
    for (int g = 0; g < 7; g++)
      for (int w = 0; w < 2; w++)
        if (a == bases[g] + 4 * w) begin
          v = (g == 0) ? mStatus : (g < 3) ? mMask : (g < 5) ? mSense : mPol;
          for (int i = 0; i < N; i++) if (i / 32 == w) r[i % 32] = v[i];
        end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mMask = '0; mSense = '0; mPol = '0;
      mStatus = '0; mOut = '0; mEn = 0; mEdge = 0; mBusy = 0; mIdx = 0;
    end else begin
      logic [N-1:0] nStatus, nOut, nMask, nSense, nPol;
      bit nBusy; int nIdx;
      for (int i = 0; i < N; i++) begin
        bit lvl, edg, ev, fire;
        lvl  = mPol[i] ? mS2[i] : !mS2[i];
        edg  = mPol[i] ? (mS2[i] && !mPrev[i]) : (!mS2[i] && mPrev[i]);
        ev   = mSense[i] ? (lvl && !mEdge) : edg;
        fire = mBusy && (mIdx == i) && mStatus[i] && !mMask[i];
        nStatus[i] = (mStatus[i] && !wHit('h40, i) && !fire) || ev;
        nOut[i]    = fire;
        nMask[i]   = wHit('hC0, i) ? 1'b1 : wHit('h100, i) ? 1'b0 : mMask[i];
        nSense[i]  = wHit('h180, i) ? 1'b1 : wHit('h1C0, i) ? 1'b0 : mSense[i];
        nPol[i]    = wHit('h240, i) ? 1'b1 : wHit('h280, i) ? 1'b0 : mPol[i];
      end
      nBusy = mBusy; nIdx = mIdx;
      if (mBusy) begin
        if (mIdx == N - 1) nBusy = 0; else nIdx = mIdx + 1;
      end
      if (busWrEn && int'(busAddr) == 'h300) begin
        mEn = busWdata[0]; mEdge = busWdata[1];
        if (busWdata[2] && busWdata[0] && !mBusy) begin nBusy = 1; nIdx = 0; end
      end
      mBusy = nBusy; mIdx = nIdx;
      mStatus = nStatus; mOut = nOut; mMask = nMask; mSense = nSense; mPol = nPol;
      mPrev = mS2; mS2 = mS1; mS1 = irqIn;
    end
  end

  // per-cycle comparison and pulse bookkeeping
  int pulseCnt[N];
  int firstCyc[N];
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      chk("R10 irqOut vs model", 64'(irqOut), 64'(mOut));
      chk((int'(busAddr) == 'h300) ? "R8 control readback" : "R2 register readback",
          64'(busRdata), 64'(mRead(int'(busAddr))));
      for (int i = 0; i < N; i++)
        if (irqOut[i]) begin
          if (pulseCnt[i] == 0) firstCyc[i] = cyc;
          pulseCnt[i]++;
        end
    end
  end

  // ---------- stimulus helpers (called at a falling edge) ----------
  task automatic wr(input int a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdExp(input int a, input logic [31:0] e, input string tag);
    busAddr = ADDR_W'(a);
    #1;
    chk(tag, 64'(busRdata), 64'(e));
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin pulseCnt[i] = 0; firstCyc[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    chk("R9 irqOut after reset", 64'(irqOut), 64'h0);
    rdExp('h300, 32'h0, "R9 control");
    rdExp('h40, 32'h0, "R9 status");
    rdExp('hC0, 32'h0, "R9 mask");
    rdExp('h184, 32'h0, "R9 sense");

    // R2 / R1: set and clear pairs, unimplemented bits
    wr('hC0, 32'hF0);
    rdExp('hC0, 32'hF0, "R2 mask set");
    rdExp('h100, 32'hF0, "R2 mask via clear offset");
    wr('h100, 32'h30);
    rdExp('hC0, 32'hC0, "R2 mask clear");
    wr('hC4, 32'hFFFF_FFFF);
    rdExp('hC4, 32'hFF, "R1 upper word only 8 lines");
    wr('h100, 32'hFFFF_FFFF);
    wr('h104, 32'hFFFF_FFFF);
    rdExp('hC0, 32'h0, "R2 mask cleared");

    // R3 / R4: rising on line 0, falling on line 1, enable clear
    wr('h240, 32'h1);
    irqIn[0] = 1'b1; idle(4);
    rdExp('h40, 32'h1, "R4 rising recorded while disabled");
    irqIn[0] = 1'b0;
    irqIn[1] = 1'b1; idle(4);
    rdExp('h40, 32'h1, "R3 rise ignored on falling line");
    irqIn[1] = 1'b0; idle(4);
    rdExp('h40, 32'h3, "R3 falling recorded");

    // R5 acknowledge, R3 level high on line 2
    wr('h40, 32'h1);
    rdExp('h40, 32'h2, "R5 ack clears");
    wr('h240, 32'h4);
    wr('h180, 32'h4);
    irqIn[2] = 1'b1; idle(4);
    rdExp('h40, 32'h6, "R3 level high recorded");
    wr('h40, 32'h4);
    rdExp('h40, 32'h6, "R5 held level re-records");
    irqIn[2] = 1'b0; idle(4);
    wr('h40, 32'h4);
    rdExp('h40, 32'h2, "R5 ack after level drops");
    wr('h184, 32'h8);
    idle(2);
    rdExp('h44, 32'h8, "R1 line 35 level low in upper word");

    // R6 edge-only
    wr('h300, 32'h2);
    wr('h44, 32'h8);
    idle(3);
    rdExp('h44, 32'h0, "R6 level low suppressed");
    rdExp('h300, 32'h2, "R8 edge-only readback");
    irqIn[2] = 1'b1; idle(4);
    rdExp('h40, 32'h2, "R6 level high suppressed");
    irqIn[0] = 1'b1; idle(4);
    rdExp('h40, 32'h3, "R6 edge still recorded");
    wr('h300, 32'h0);
    idle(3);
    rdExp('h40, 32'h7, "R6 levels record again");
    rdExp('h44, 32'h8, "R6 upper level again");
    irqIn[2] = 1'b0; irqIn[35] = 1'b1; idle(4);

    // R8 flush with enable clear is ignored
    wr('h300, 32'h4);
    rdExp('h300, 32'h0, "R8 flush without enable");
    idle(2);
    rdExp('h40, 32'h7, "R8 status untouched");

    // R5 ack colliding with a fresh edge
    irqIn[0] = 1'b0; idle(4);
    wr('h40, 32'h1);
    rdExp('h40, 32'h6, "R5 ack line 0");
    irqIn[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr('h40, 32'h1);
    rdExp('h40, 32'h7, "R5 event wins over same-cycle ack");

    // R7 / R8 replay with line 1 masked
    wr('hC0, 32'h2);
    for (int i = 0; i < N; i++) pulseCnt[i] = 0;
    wr('h300, 32'h5);
    rdExp('h300, 32'h5, "R8 flush bit reads 1");
    wr('h300, 32'h5);
    busAddr = ADDR_W'('h300);
    idle(N + 4);
    rdExp('h300, 32'h1, "R8 flush self-clears");
    rdExp('h40, 32'h2, "R7 masked line stays recorded");
    rdExp('h44, 32'h0, "R7 replayed upper line cleared");
    chk("R7 line 0 pulses", 64'(pulseCnt[0]), 64'd1);
    chk("R7 line 1 masked no pulse", 64'(pulseCnt[1]), 64'd0);
    chk("R7 line 2 pulses", 64'(pulseCnt[2]), 64'd1);
    chk("R7 line 35 pulses", 64'(pulseCnt[35]), 64'd1);
    chk("R7 ascending spacing 2", 64'(firstCyc[2] - firstCyc[0]), 64'd2);
    chk("R7 ascending spacing 35", 64'(firstCyc[35] - firstCyc[0]), 64'd35);
    chk("R10 idle after replay", 64'(irqOut), 64'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule